// File: doc/BRIEF.md
# Dual-Port Mailbox Memory with Cross-Port Interrupts

This block is a 2048 x 8 storage array that two processors share through two independent ports, A and B. Each port can read or write any location in the same clock cycle as the other port. The two highest addresses also serve as doorbells. When port B writes the lower of the two, port A's active-low interrupt goes low. When port A writes the top address, port B's interrupt goes low. The receiving port clears its interrupt with an enabled output access to its own mailbox address. The byte stored there is the message, and it stays ordinary storage.

Each port has an active-low busy input from an external arbiter. While it is low, that port cannot store data and cannot change any interrupt flag. Read data is registered. Each port has a data-valid strobe instead of a high-impedance output, and the strobe shows when the registered byte belongs to a read.

Top module: `dp_mailbox_ram`

## Requirements
- R1: The array holds 2^ADDR_W words of DATA_W bits (default 2048 x 8). A byte written through either port at any address, including address 0, reads back unchanged through either port.
- R2: A port writes when `cs_n` = 0 and `we_n` = 0 and `busy_n` = 1. The level of `oe_n` does not affect a write.
- R3: A read is `cs_n` = 0, `we_n` = 1, `oe_n` = 0. One clock after a read, `rvalid` = 1 and `rdata` holds the addressed byte. After any other cycle (deselected, `oe_n` = 1, or a write), `rvalid` = 0 and `rdata` = 0.
- R4: A write by port B to address 2^ADDR_W-2 (0x7FE) drives `a_irq_n` low one clock later.
- R5: An access by port A with `a_cs_n` = 0, `a_oe_n` = 0, `a_busy_n` = 1 and address 0x7FE drives `a_irq_n` high one clock later, whatever the level of `a_we_n`.
- R6: A write by port A to address 2^ADDR_W-1 (0x7FF) drives `b_irq_n` low one clock later. An access by port B with `b_cs_n` = 0, `b_oe_n` = 0, `b_busy_n` = 1 at 0x7FF drives it high one clock later.
- R7: Mailbox addresses store and return data like any other location. A read that clears a flag returns the stored message.
- R8: While a port's `busy_n` is 0, that port's writes do not change the array, it cannot set the other port's flag, and it cannot clear its own flag. Its reads still return data.
- R9: During and after reset, both `irq_n` outputs are 1 and both `rvalid` outputs are 0. Reset clears a pending flag.
- R10: If a set and a clear of the same flag fall on the same clock edge, the flag ends up set.
- R11: A read and a write by the other port to the same address in the same cycle return the old byte. If both ports write the same address in the same cycle, port B's byte is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_cs_n | input | 1 | Port A select, active low |
| a_we_n | input | 1 | Port A write enable, active low |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_busy_n | input | 1 | Port A busy, active low; suppresses writes and flag changes |
| a_addr | input | ADDR_W | Port A address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A registered read data, 0 when not valid |
| a_rvalid | output | 1 | Port A read data valid |
| a_irq_n | output | 1 | Port A interrupt, active low |
| b_cs_n | input | 1 | Port B select, active low |
| b_we_n | input | 1 | Port B write enable, active low |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_busy_n | input | 1 | Port B busy, active low; suppresses writes and flag changes |
| b_addr | input | ADDR_W | Port B address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B registered read data, 0 when not valid |
| b_rvalid | output | 1 | Port B read data valid |
| b_irq_n | output | 1 | Port B interrupt, active low |

## Verification
The bench drives the following control patterns on each port:
- plain reads and plain writes;
- writes with `oe_n` low;
- `oe_n` high reads;
- deselected cycles with `oe_n` low.

These patterns separate the read-valid decode from the write decode. For the mailboxes, the bench sets a flag and then clears it with a read, and clears a flag through a write that has `oe_n` low. It also blocks a set and a clear with busy, and sets and clears the same flag in one cycle. Together these show whether each flag follows the correct port, address and priority.

Same-address collisions show which byte the array keeps and which byte a read returns. A reset while a flag is pending shows that the flags clear.

// File: rtl/dp_mailbox_ram.sv
module dp_mailbox_ram #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_cs_n,
  input  logic              a_we_n,
  input  logic              a_oe_n,
  input  logic              a_busy_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_rvalid,
  output logic              a_irq_n,
  input  logic              b_cs_n,
  input  logic              b_we_n,
  input  logic              b_oe_n,
  input  logic              b_busy_n,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_rvalid,
  output logic              b_irq_n
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] BOX_A = ADDR_W'(DEPTH - 2);
  localparam logic [ADDR_W-1:0] BOX_B = ADDR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] a_q, b_q;
  logic flag_a, flag_b;

  wire a_wr  = !a_cs_n && !a_we_n && a_busy_n;
  wire b_wr  = !b_cs_n && !b_we_n && b_busy_n;
  wire a_rd  = !a_cs_n && a_we_n && !a_oe_n;
  wire b_rd  = !b_cs_n && b_we_n && !b_oe_n;
  wire a_set = b_wr && (b_addr == BOX_A);
  wire b_set = a_wr && (a_addr == BOX_B);
  wire a_clr = !a_cs_n && !a_oe_n && a_busy_n && (a_addr == BOX_A);
  wire b_clr = !b_cs_n && !b_oe_n && b_busy_n && (b_addr == BOX_B);

  always_ff @(posedge clk) begin
    if (a_wr) mem[a_addr] <= a_wdata;
    if (b_wr) mem[b_addr] <= b_wdata;
    a_q <= mem[a_addr];
    b_q <= mem[b_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rvalid <= 1'b0;
      b_rvalid <= 1'b0;
      flag_a   <= 1'b0;
      flag_b   <= 1'b0;
    end else begin
      a_rvalid <= a_rd;
      b_rvalid <= b_rd;
      if (a_set)      flag_a <= 1'b1;
      else if (a_clr) flag_a <= 1'b0;
      if (b_set)      flag_b <= 1'b1;
      else if (b_clr) flag_b <= 1'b0;
    end
  end

  assign a_rdata = a_rvalid ? a_q : '0;
  assign b_rdata = b_rvalid ? b_q : '0;
  assign a_irq_n = !flag_a;
  assign b_irq_n = !flag_b;

  AST_A_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!b_cs_n && !b_we_n && b_busy_n && b_addr == BOX_A) |=> !a_irq_n); // R4
  AST_A_IRQ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_cs_n && !a_oe_n && a_busy_n && a_addr == BOX_A &&
     !(!b_cs_n && !b_we_n && b_busy_n && b_addr == BOX_A)) |=> a_irq_n); // R5
  AST_B_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_cs_n && !a_we_n && a_busy_n && a_addr == BOX_B) |=> !b_irq_n); // R6
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_busy_n && !(!b_cs_n && !b_oe_n && b_busy_n && b_addr == BOX_B))
    |=> $stable(b_irq_n)); // R8
  AST_RVALID_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (a_cs_n || a_oe_n || !a_we_n) |=> (!a_rvalid && a_rdata == '0)); // R3
endmodule

// File: tb/dp_mailbox_ram_tb.sv
module dp_mailbox_ram_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic a_cs_n, a_we_n, a_oe_n, a_busy_n, b_cs_n, b_we_n, b_oe_n, b_busy_n;
  logic [10:0] a_addr, b_addr;
  logic [7:0] a_wdata, b_wdata, a_rdata, b_rdata;
  logic a_rvalid, b_rvalid, a_irq_n, b_irq_n;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dp_mailbox_ram u_dut (
    .clk(clk), .rst_n(rst_n),
    .a_cs_n(a_cs_n), .a_we_n(a_we_n), .a_oe_n(a_oe_n), .a_busy_n(a_busy_n),
    .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata), .a_rvalid(a_rvalid),
    .a_irq_n(a_irq_n),
    .b_cs_n(b_cs_n), .b_we_n(b_we_n), .b_oe_n(b_oe_n), .b_busy_n(b_busy_n),
    .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata), .b_rvalid(b_rvalid),
    .b_irq_n(b_irq_n));

  // control nibble {cs_n, we_n, oe_n, busy_n}
  localparam logic [3:0] IDL = 4'b1111, WR = 4'b0011, RD = 4'b0101,
                         WRO = 4'b0001, OEH = 4'b0111, DSO = 4'b1101,
                         WRB = 4'b0010, RDB = 4'b0100;
  localparam int N = 19;
  // {A ctl, addr, wdata, B ctl, addr, wdata, exp A rv, rdata, irq_n, exp B rv, rdata, irq_n}
  localparam logic [65:0] VEC [N] = '{
    {WR,  11'h010, 8'h5A, IDL, 11'h000, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1},
    {IDL, 11'h000, 8'h00, RD,  11'h010, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1, 8'h5A, 1'b1},
    {RD,  11'h010, 8'h00, WRO, 11'h020, 8'hA5, 1'b1, 8'h5A, 1'b1, 1'b0, 8'h00, 1'b1},
    {RD,  11'h020, 8'h00, OEH, 11'h020, 8'h00, 1'b1, 8'hA5, 1'b1, 1'b0, 8'h00, 1'b1},
    {WR,  11'h7FF, 8'h33, DSO, 11'h020, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0},
    {IDL, 11'h000, 8'h00, WR,  11'h7FE, 8'hC3, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0},
    {RD,  11'h7FE, 8'h00, IDL, 11'h000, 8'h00, 1'b1, 8'hC3, 1'b1, 1'b0, 8'h00, 1'b0},
    {IDL, 11'h000, 8'h00, WRO, 11'h7FF, 8'h77, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1},
    {RD,  11'h7FF, 8'h00, IDL, 11'h000, 8'h00, 1'b1, 8'h77, 1'b1, 1'b0, 8'h00, 1'b1},
    {WRB, 11'h7FF, 8'h99, IDL, 11'h000, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1},
    {IDL, 11'h000, 8'h00, RD,  11'h7FF, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1, 8'h77, 1'b1},
    {IDL, 11'h000, 8'h00, WR,  11'h7FE, 8'h11, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1},
    {RDB, 11'h7FE, 8'h00, IDL, 11'h000, 8'h00, 1'b1, 8'h11, 1'b0, 1'b0, 8'h00, 1'b1},
    {RD,  11'h7FE, 8'h00, WR,  11'h7FE, 8'h22, 1'b1, 8'h11, 1'b0, 1'b0, 8'h00, 1'b1},
    {RD,  11'h7FE, 8'h00, IDL, 11'h000, 8'h00, 1'b1, 8'h22, 1'b1, 1'b0, 8'h00, 1'b1},
    {WR,  11'h030, 8'h01, WR,  11'h030, 8'h02, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1},
    {RD,  11'h030, 8'h00, IDL, 11'h000, 8'h00, 1'b1, 8'h02, 1'b1, 1'b0, 8'h00, 1'b1},
    {WR,  11'h000, 8'hEE, IDL, 11'h000, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1},
    {IDL, 11'h000, 8'h00, RD,  11'h000, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1, 8'hEE, 1'b1}
  };
  localparam string TAG [N] = '{"R1", "R1", "R2", "R3", "R6", "R4", "R5", "R6",
    "R7", "R8", "R8", "R4", "R8", "R10", "R11", "R11", "R11", "R1", "R1"};

  task automatic drive(input logic [45:0] s);
    {a_cs_n, a_we_n, a_oe_n, a_busy_n, a_addr, a_wdata,
     b_cs_n, b_we_n, b_oe_n, b_busy_n, b_addr, b_wdata} = s;
  endtask

  task automatic check(input string tag, input string what,
                       input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [45:0] s);
    @(negedge clk); drive(s);
    @(posedge clk); #1;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    drive({IDL, 11'h0, 8'h0, IDL, 11'h0, 8'h0});
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    check("R9", "reset A", {a_rvalid, a_rdata, a_irq_n}, 10'b0_00000000_1);
    check("R9", "reset B", {b_rvalid, b_rdata, b_irq_n}, 10'b0_00000000_1);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < N; i++) begin
      step(VEC[i][65:20]);
      check(TAG[i], $sformatf("vec %0d port A", i), {a_rvalid, a_rdata, a_irq_n}, VEC[i][19:10]);
      check(TAG[i], $sformatf("vec %0d port B", i), {b_rvalid, b_rdata, b_irq_n}, VEC[i][9:0]);
    end
    // R4 / R9: pending flag cleared by reset
    step({IDL, 11'h0, 8'h0, WR, 11'h7FE, 8'h44});
    check("R4", "flag pending", {9'b0, a_irq_n}, 10'd0);
    @(negedge clk); rst_n = 1'b0; #1;
    check("R9", "reset clears flag", {a_rvalid, a_rdata, a_irq_n}, 10'b0_00000000_1);
    @(negedge clk); rst_n = 1'b1;
    // R7: message survives reset as storage
    step({RD, 11'h7FE, 8'h0, IDL, 11'h0, 8'h0});
    check("R7", "mailbox byte", {a_rvalid, a_rdata, a_irq_n}, {1'b1, 8'h44, 1'b1});
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule